// File: doc/BRIEF.md
# Chained Multiply-Accumulate Carry Unit

This unit computes the exact unsigned value A·B + C from three 64-bit operands and returns all 128 bits of it. The lower word goes to a low-result port. The upper word goes to a high-result port. The high word is sized and placed so that it can be passed straight back as the C operand of the following operation. A scalar-by-bigint multiply can then be built one word at a time, with the high result carrying between words. The first word of such a chain uses C = 0.

A one-cycle `start` pulse captures the operands and the unit goes busy. A radix-2 shift-and-add datapath then retires one multiplier bit per clock. The addend is loaded into the upper half of the accumulator, so after the last shift it ends up aligned with the product's least significant bit, with no extra addition pass. When the last step finishes, `done` pulses for one cycle. Both results then hold their values until the next operation completes. The unit produces no flags of any kind.

Top module: `mac_chain_unit`

## Requirements
- R1: While reset is held and in the first cycle after it, `busy`, `done`, `res_lo` and `res_hi` are all zero.
- R2: A `start` sampled high while `busy` is low latches `op_a`, `op_b` and `op_c`, and `busy` is high from the next cycle.
- R3: `{res_hi,res_lo}` equals the unsigned 128-bit value op_a·op_b + op_c exactly. No product bit is dropped and no overflow can occur: with all three operands at all-ones, `res_hi` is all-ones and `res_lo` is zero.
- R4: `op_c` is zero-extended. It is never shifted or sign-extended, so C with bit 63 set and A = 0 gives `res_hi` = 0 and `res_lo` = C.
- R5: `res_lo` equals (op_a·op_b + op_c) mod 2^64.
- R6: `res_hi` is bits 127:64 of the sum. When it is fed back as `op_c` across consecutive words, the collected `res_lo` words followed by the final `res_hi` form the exact product of the multiword number and the scalar.
- R7: `done` is high for exactly one cycle, on the 64th rising edge after the edge that accepted `start`. `busy` falls on that same edge.
- R8: `res_lo` and `res_hi` change only on the edge that raises `done`. They hold while a later operation is busy.
- R9: `start` while `busy` is high is ignored. The running operation completes with its original operands and no second operation follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin an operation; accepted only while idle |
| op_a | input | 64 | Multiplicand |
| op_b | input | 64 | Multiplier |
| op_c | input | 64 | Addend, or the carry from the previous chained word |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| res_lo | output | 64 | Bits 63:0 of the sum |
| res_hi | output | 64 | Bits 127:64 of the sum; carry for the next word |

## Verification
The hardest case to reach from the ports is the largest possible accumulator value. Every partial sum must then carry out of the upper word while the addend is still shifting down, and random operands almost never produce this. Directed all-ones operands force that carry on every step, and an addend with only its top bit set shows whether it is treated as a sign. A three-word chain feeds each high result back as the next addend and compares the whole result against a wide reference. A second `start` issued mid-operation checks that the running operands and the held results are not disturbed.

// File: rtl/mac_chain_unit.sv
module mac_chain_unit #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic [W-1:0] op_c,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] res_lo,
  output logic [W-1:0] res_hi
);
  localparam int CW = $clog2(W);

  logic [W-1:0]   mcand, acc_hi, acc_lo;
  logic [CW-1:0]  step;
  logic [W:0]     partial;
  logic [2*W-1:0] shifted;
  logic           last;

  // Addend preloaded into the upper half lands at bit 0 after W right shifts.
  assign partial = {1'b0, acc_hi} + (acc_lo[0] ? {1'b0, mcand} : '0);
  assign shifted = {partial, acc_lo[W-1:1]};
  assign last    = (step == CW'(W - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      step   <= '0;
      mcand  <= '0;
      acc_hi <= '0;
      acc_lo <= '0;
      res_lo <= '0;
      res_hi <= '0;
    end else begin
      done <= 1'b0;
      if (!busy && start) begin
        mcand  <= op_a;
        acc_hi <= op_c;
        acc_lo <= op_b;
        step   <= '0;
        busy   <= 1'b1;
      end else if (busy) begin
        acc_hi <= shifted[2*W-1:W];
        acc_lo <= shifted[W-1:0];
        step   <= step + 1'b1;
        if (last) begin
          busy   <= 1'b0;
          done   <= 1'b1;
          res_hi <= shifted[2*W-1:W];
          res_lo <= shifted[W-1:0];
        end
      end
    end
  end
endmodule

// File: rtl/mac_chain_unit_chk.sv
module mac_chain_unit_chk #(
  parameter int W = 64
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic [W-1:0] op_a,
  input logic [W-1:0] op_b,
  input logic [W-1:0] op_c,
  input logic         busy,
  input logic         done,
  input logic [W-1:0] res_lo,
  input logic [W-1:0] res_hi
);
  logic [2*W-1:0] exp_q;
  int unsigned    cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      exp_q <= '0;
      cnt   <= 0;
    end else if (start && !busy) begin
      exp_q <= {{W{1'b0}}, op_a} * {{W{1'b0}}, op_b} + {{W{1'b0}}, op_c};
      cnt   <= 0;
    end else if (busy) begin
      cnt <= cnt + 1;
    end
  end

  p_accept_r2:   assert property (@(posedge clk) disable iff (!rst_n) (start && !busy) |=> busy);
  p_result_r3:   assert property (@(posedge clk) disable iff (!rst_n) done |-> ({res_hi, res_lo} == exp_q));
  p_latency_r7:  assert property (@(posedge clk) disable iff (!rst_n) done |-> (cnt == W));
  p_pulse_r7:    assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  p_hold_r8:     assert property (@(posedge clk) disable iff (!rst_n) !done |-> ($stable(res_lo) && $stable(res_hi)));
  p_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n) !(busy && done));
endmodule

bind mac_chain_unit mac_chain_unit_chk #(.W(W)) u_chk (.*);

// File: tb/test_mac_chain_unit.sv
`timescale 1ns/1ps
module test_mac_chain_unit;
  localparam int W = 64;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [W-1:0] op_a = '0, op_b = '0, op_c = '0;
  logic         busy, done;
  logic [W-1:0] res_lo, res_hi;

  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  mac_chain_unit #(.W(W)) i_mac_chain_unit (
    .clk(clk), .rst_n(rst_n), .start(start),
    .op_a(op_a), .op_b(op_b), .op_c(op_c),
    .busy(busy), .done(done), .res_lo(res_lo), .res_hi(res_hi)
  );

  function automatic logic [2*W-1:0] ref_mac(input logic [W-1:0] a, b, c);
    logic [2*W-1:0] wa, wb, wc;
    wa = {{W{1'b0}}, a};
    wb = {{W{1'b0}}, b};
    wc = {{W{1'b0}}, c};
    return wa * wb + wc;
  endfunction

  task automatic check(input string req, input logic [2*W-1:0] act, exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  logic [2*W-1:0] got;
  int             lat;

  // Launch one operation and wait for done; got/lat carry results.
  task automatic run_op(input logic [W-1:0] a, b, c, input bit poke_busy);
    @(negedge clk);
    start = 1'b1; op_a = a; op_b = b; op_c = c;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    check("R2 busy after start", {127'b0, busy}, 128'd1);
    while (!done && lat < 1000) begin
      if (poke_busy && lat == 10) begin
        start = 1'b1; op_a = ~a; op_b = ~b; op_c = ~c;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      lat++;
    end
    start = 1'b0;
    got = {res_hi, res_lo};
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    report();
  end

  initial begin
    logic [2*W-1:0] e, prev;
    logic [W-1:0]   ra, rb, rc, s, carry;
    logic [W-1:0]   x [3];
    logic [4*W-1:0] big_exp, big_got;
    void'($urandom(32'd2024));

    repeat (3) @(negedge clk);
    check("R1 reset busy/done", {126'b0, busy, done}, 128'd0);
    check("R1 reset outputs", {res_hi, res_lo}, 128'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 first cycle after reset", {res_hi, res_lo} | {126'b0, busy, done}, 128'd0);

    // R3 all-ones: no overflow, hi all ones, lo zero
    run_op('1, '1, '1, 1'b0);
    check("R3 all-ones", got, {{W{1'b1}}, {W{1'b0}}});
    check("R7 latency", 128'(lat), 128'(W + 1));
    check("R7 busy low at done", {127'b0, busy}, 128'd0);
    @(negedge clk);
    check("R7 done one cycle", {127'b0, done}, 128'd0);

    // R4 zero extension of the addend
    run_op('0, 64'h1234, 64'h8000_0000_0000_0001, 1'b0);
    check("R4 addend zero-extended", got, {64'h0, 64'h8000_0000_0000_0001});
    run_op(64'h2, 64'h3, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0);
    check("R4 addend carry into hi", got, ref_mac(64'h2, 64'h3, '1));

    // zero operands
    run_op('0, '0, '0, 1'b0);
    check("R3 all-zero", got, 128'd0);

    // random operands
    for (int i = 0; i < 40; i++) begin
      ra = {$urandom, $urandom};
      rb = {$urandom, $urandom};
      rc = {$urandom, $urandom};
      if (i % 5 == 0) rb = '1;
      run_op(ra, rb, rc, 1'b0);
      e = ref_mac(ra, rb, rc);
      check("R3 random full sum", got, e);
      check("R5 random low word", {64'b0, got[W-1:0]}, {64'b0, e[W-1:0]});
      check("R7 random latency", 128'(lat), 128'(W + 1));
    end

    // R8 hold during next op, R9 start while busy ignored
    ra = 64'hDEAD_BEEF_0000_1111; rb = 64'h0123_4567_89AB_CDEF; rc = 64'h5;
    run_op(ra, rb, rc, 1'b0);
    prev = got;
    @(negedge clk);
    start = 1'b1; op_a = 64'h7; op_b = 64'h9; op_c = 64'h1;
    @(negedge clk);
    start = 1'b0;
    repeat (20) @(negedge clk);
    check("R8 outputs held while busy", {res_hi, res_lo}, prev);
    while (!done) @(negedge clk);
    check("R8 update at done", {res_hi, res_lo}, 128'd64);
    run_op(ra, rb, rc, 1'b1);
    check("R9 start while busy ignored", got, ref_mac(ra, rb, rc));
    @(negedge clk);
    @(negedge clk);
    check("R9 no second operation", {126'b0, busy, done}, 128'd0);

    // R6 three-word carry chain
    s = {$urandom, $urandom} | 64'h8000_0000_0000_0000;
    x[0] = '1; x[1] = {$urandom, $urandom}; x[2] = '1;
    carry = '0;
    big_got = '0;
    for (int k = 0; k < 3; k++) begin
      run_op(x[k], s, carry, 1'b0);
      big_got[k*W +: W] = res_lo;
      carry = res_hi;
    end
    big_got[3*W +: W] = carry;
    big_exp = {{W{1'b0}}, x[2], x[1], x[0]} * {{3*W{1'b0}}, s};
    check("R6 chain words 0-1", big_got[2*W-1:0], big_exp[2*W-1:0]);
    check("R6 chain words 2-3", big_got[4*W-1:2*W], big_exp[4*W-1:2*W]);

    report();
  end
endmodule